// File: doc/BRIEF.md
# Converter Host Bus Interface

This block is the parallel host port of a data converter. A processor reaches it through chip-select, a read strobe and one address line. The address line picks one of two sources: an 8-bit status register or the latest conversion result. In wide mode the result is returned as one 16-bit word. In byte mode it is returned as two bytes on successive reads. The block produces a bus value and a separate drive-enable; the 3-state pad cell sits outside it and uses both.

An active-low end-of-conversion line, `eoc_n`, suits an interrupt or DMA request. It falls when a result is latched. It rises a fixed number of clocks after the host starts a read of the result, or at once when a new conversion starts. A status read made while the hold/convert input is low acts as a software reset. The software reset clears the status, raises `eoc_n` and sets a calibration-request flag.

All strobes are sampled on the rising edge of `clk`. The bus value and its enable are registered, so each appears one clock after the strobe that selects it.

Top module: `cnv_host_bus`

## Requirements
- R1: `bus_oe` is 1 in the clock after an edge that samples `cs_n` and `rd_n` both low. After any other edge it is 0.
- R2: A read start is the edge at which `cs_n` and `rd_n` become both low. At a read start, `bus_q` latches the status zero-extended to 16 bits when `addr_sel`=0, or result data when `addr_sel`=1. `bus_q` holds that value for the rest of the read.
- R3: Status bit 6 (mask 0x40) is 1 from a `done_pulse` until the next conversion start or software reset. A conversion start is an edge that samples `hold_n` going from 1 to 0.
- R4: `eoc_n` is 0 after an edge that samples `done_pulse`=1.
- R5: A read start with `addr_sel`=1 while `eoc_n` is 0 releases `eoc_n`. It stays 0 after that edge and the next one, and is 1 after the third edge (EOC_DELAY=3).
- R6: `eoc_n` is 1 after the edge that samples a conversion start, provided `done_pulse` is 0 at that edge.
- R7: A read start with `addr_sel`=0 while `hold_n`=0 is a software reset. It sets `eoc_n` to 1 and clears bit 6. It sets status bit 0 (calibration request), so the status reads 0x01. Bit 0 is cleared again by the next conversion start.
- R8: With `wide_mode`=1, a result read returns all 16 result bits. Repeated reads return the same word.
- R9: With `wide_mode`=0, result reads return bits 15:8 and then bits 7:0 in the low byte of `bus_q`, with the upper byte 0, and then alternate. Each `done_pulse` restarts the order at the high byte.
- R10: After `rst`, `bus_oe`=0, `eoc_n`=1, and the status reads 0x00.
- R11: A status read with `hold_n`=1 is ignored by the status register and by `eoc_n`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cs_n | input | 1 | Chip select, active low |
| rd_n | input | 1 | Read strobe, active low |
| addr_sel | input | 1 | 0 = status, 1 = result |
| hold_n | input | 1 | Hold/convert; a falling edge starts a conversion |
| wide_mode | input | 1 | 1 = 16-bit result reads, 0 = two byte reads |
| done_pulse | input | 1 | One-clock pulse from the converter core when a result is ready |
| done_result | input | 16 | Result word that comes with `done_pulse` |
| bus_q | output | 16 | Registered bus value |
| bus_oe | output | 1 | Registered drive-enable for the 3-state pads |
| eoc_n | output | 1 | End of conversion, active low |

## Verification
The hardest case to reach from the ports is the software reset. It needs a status read that begins while `hold_n` is low, and it needs `eoc_n` already low so that the release can be seen. The bench gets there in three steps. It drops `hold_n`, which starts a conversion. It pulses `done_pulse` while `hold_n` is still low, which pulls `eoc_n` down. It then issues the status read. After the reset, the bench raises `hold_n` and reads the status again to check for the calibration-request value. A further conversion start then shows that the flag clears.

// File: rtl/cnv_host_pkg.sv
package cnv_host_pkg;
  localparam int STAT_W     = 8;
  localparam int ST_CAL_REQ = 0;
  localparam int ST_READY   = 6;
endpackage

// File: rtl/cnv_strobe_detect.sv
module cnv_strobe_detect (
  input  logic clk,
  input  logic rst,
  input  logic cs_n,
  input  logic rd_n,
  input  logic hold_n,
  output logic rd_act,
  output logic rd_start,
  output logic conv_start
);
  logic rd_act_q;
  logic hold_q;

  assign rd_act     = !cs_n && !rd_n;
  assign rd_start   = rd_act && !rd_act_q;
  assign conv_start = hold_q && !hold_n;

  always_ff @(posedge clk) begin
    if (rst) begin
      rd_act_q <= 1'b0;
      hold_q   <= 1'b1;
    end else begin
      rd_act_q <= rd_act;
      hold_q   <= hold_n;
    end
  end
endmodule

// File: rtl/cnv_eoc_ctrl.sv
module cnv_eoc_ctrl #(
  parameter int EOC_DELAY = 3
) (
  input  logic clk,
  input  logic rst,
  input  logic sw_reset,
  input  logic conv_done,
  input  logic conv_start,
  input  logic result_read,
  output logic eoc_n
);
  localparam int CNT_W = $clog2(EOC_DELAY + 1);

  logic [CNT_W-1:0] cnt_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      eoc_n <= 1'b1;
      cnt_q <= '0;
    end else if (sw_reset) begin
      eoc_n <= 1'b1;
      cnt_q <= '0;
    end else if (conv_done) begin
      eoc_n <= 1'b0;
      cnt_q <= '0;
    end else if (conv_start) begin
      eoc_n <= 1'b1;
      cnt_q <= '0;
    end else if (cnt_q != '0) begin
      cnt_q <= cnt_q - 1'b1;
      if (cnt_q == CNT_W'(1)) eoc_n <= 1'b1;
    end else if (result_read && !eoc_n) begin
      if (EOC_DELAY <= 1) eoc_n <= 1'b1;
      else cnt_q <= CNT_W'(EOC_DELAY - 1);
    end
  end
endmodule

// File: rtl/cnv_result_port.sv
module cnv_result_port
  import cnv_host_pkg::*;
#(
  parameter int DATA_W = 16
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              conv_done,
  input  logic [DATA_W-1:0] done_result,
  input  logic              rd_start,
  input  logic              addr_sel,
  input  logic              wide_mode,
  input  logic [STAT_W-1:0] status,
  output logic [DATA_W-1:0] bus_q
);
  localparam int BYTE_W = DATA_W / 2;

  logic [DATA_W-1:0] result_q;
  logic              lo_next_q;
  logic [DATA_W-1:0] rd_word;

  always_comb begin
    if (!addr_sel)      rd_word = DATA_W'(status);
    else if (wide_mode) rd_word = result_q;
    else if (lo_next_q) rd_word = DATA_W'(result_q[BYTE_W-1:0]);
    else                rd_word = DATA_W'(result_q[DATA_W-1:BYTE_W]);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      result_q  <= '0;
      lo_next_q <= 1'b0;
      bus_q     <= '0;
    end else begin
      if (rd_start) bus_q <= rd_word;
      if (conv_done) begin
        result_q  <= done_result;
        lo_next_q <= 1'b0;
      end else if (rd_start && addr_sel && !wide_mode) begin
        lo_next_q <= !lo_next_q;
      end
    end
  end
endmodule

// File: rtl/cnv_host_bus.sv
module cnv_host_bus
  import cnv_host_pkg::*;
#(
  parameter int DATA_W    = 16,
  parameter int EOC_DELAY = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cs_n,
  input  logic              rd_n,
  input  logic              addr_sel,
  input  logic              hold_n,
  input  logic              wide_mode,
  input  logic              done_pulse,
  input  logic [DATA_W-1:0] done_result,
  output logic [DATA_W-1:0] bus_q,
  output logic              bus_oe,
  output logic              eoc_n
);
  logic              rd_act, rd_start, conv_start, sw_reset;
  logic              ready_q, cal_req_q;
  logic [STAT_W-1:0] status;

  cnv_strobe_detect u_strb (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .hold_n(hold_n),
    .rd_act(rd_act), .rd_start(rd_start), .conv_start(conv_start)
  );

  assign sw_reset = rd_start && !addr_sel && !hold_n;

  always_comb begin
    status              = '0;
    status[ST_READY]    = ready_q;
    status[ST_CAL_REQ]  = cal_req_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      ready_q   <= 1'b0;
      cal_req_q <= 1'b0;
      bus_oe    <= 1'b0;
    end else begin
      bus_oe <= rd_act;
      if (sw_reset) begin
        ready_q   <= 1'b0;
        cal_req_q <= 1'b1;
      end else begin
        if (done_pulse)      ready_q <= 1'b1;
        else if (conv_start) ready_q <= 1'b0;
        if (conv_start)      cal_req_q <= 1'b0;
      end
    end
  end

  cnv_eoc_ctrl #(.EOC_DELAY(EOC_DELAY)) u_eoc (
    .clk(clk), .rst(rst), .sw_reset(sw_reset), .conv_done(done_pulse),
    .conv_start(conv_start), .result_read(rd_start && addr_sel),
    .eoc_n(eoc_n)
  );

  cnv_result_port #(.DATA_W(DATA_W)) u_port (
    .clk(clk), .rst(rst), .conv_done(done_pulse), .done_result(done_result),
    .rd_start(rd_start), .addr_sel(addr_sel), .wide_mode(wide_mode),
    .status(status), .bus_q(bus_q)
  );
endmodule

// File: rtl/cnv_host_bus_chk.sv
module cnv_host_bus_chk (
  input logic clk,
  input logic rst,
  input logic cs_n,
  input logic rd_n,
  input logic addr_sel,
  input logic hold_n,
  input logic done_pulse,
  input logic bus_oe,
  input logic eoc_n
);
  logic hold_prev, rd_prev;

  always_ff @(posedge clk) begin
    if (rst) begin
      hold_prev <= 1'b1;
      rd_prev   <= 1'b0;
    end else begin
      hold_prev <= hold_n;
      rd_prev   <= !cs_n && !rd_n;
    end
  end

  // R1
  a_r1_oe_on: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !rd_n) |=> bus_oe);
  // R1
  a_r1_oe_off: assert property (@(posedge clk) disable iff (rst)
    (cs_n || rd_n) |=> !bus_oe);
  // R4
  a_r4_eoc_on_done: assert property (@(posedge clk) disable iff (rst)
    (done_pulse && !(!cs_n && !rd_n && !addr_sel && !hold_n)) |=> !eoc_n);
  // R6
  a_r6_eoc_conv_start: assert property (@(posedge clk) disable iff (rst)
    (hold_prev && !hold_n && !done_pulse) |=> eoc_n);
  // R7
  a_r7_sw_reset_eoc: assert property (@(posedge clk) disable iff (rst)
    (!cs_n && !rd_n && !rd_prev && !addr_sel && !hold_n) |=> eoc_n);
endmodule

bind cnv_host_bus cnv_host_bus_chk u_chk (
  .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .addr_sel(addr_sel),
  .hold_n(hold_n), .done_pulse(done_pulse), .bus_oe(bus_oe), .eoc_n(eoc_n)
);

// File: tb/cnv_host_bus_bench.sv
module cnv_host_bus_bench;
  logic        clk = 1'b0;
  logic        rst, cs_n, rd_n, addr_sel, hold_n, wide_mode, done_pulse;
  logic [15:0] done_result;
  logic [15:0] bus_q;
  logic        bus_oe, eoc_n;
  int          checks = 0;
  int          failures = 0;
  bit          finished = 1'b0;

  always #10 clk = ~clk;

  cnv_host_bus u_cnv_host_bus (
    .clk(clk), .rst(rst), .cs_n(cs_n), .rd_n(rd_n), .addr_sel(addr_sel),
    .hold_n(hold_n), .wide_mode(wide_mode), .done_pulse(done_pulse),
    .done_result(done_result), .bus_q(bus_q), .bus_oe(bus_oe), .eoc_n(eoc_n)
  );

  task automatic chk(input string req, input logic [15:0] act, input logic [15:0] exp);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic rd(input logic a, output logic [15:0] v);
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b0; addr_sel = a;
    @(negedge clk); v = bus_q;
    cs_n = 1'b1; rd_n = 1'b1;
  endtask

  task automatic convert(input logic [15:0] d);
    @(negedge clk); hold_n = 1'b0;
    @(negedge clk); hold_n = 1'b1; done_pulse = 1'b1; done_result = d;
    @(negedge clk); done_pulse = 1'b0;
  endtask

  task automatic t_reset();
    logic [15:0] v;
    chk("R10 oe", {15'b0, bus_oe}, 16'h0);
    chk("R10 eoc_n", {15'b0, eoc_n}, 16'h1);
    rd(1'b0, v); chk("R10 status", v, 16'h0000);
  endtask

  task automatic t_oe();
    @(negedge clk); cs_n = 1'b0; rd_n = 1'b1; addr_sel = 1'b0;
    @(negedge clk); chk("R1 cs only", {15'b0, bus_oe}, 16'h0);
    cs_n = 1'b1; rd_n = 1'b0;
    @(negedge clk); chk("R1 rd only", {15'b0, bus_oe}, 16'h0);
    cs_n = 1'b0;
    @(negedge clk); chk("R1 both low", {15'b0, bus_oe}, 16'h1);
    cs_n = 1'b1; rd_n = 1'b1;
    @(negedge clk); chk("R1 released", {15'b0, bus_oe}, 16'h0);
  endtask

  task automatic t_wide();
    logic [15:0] v;
    wide_mode = 1'b1;
    convert(16'hBEEF);
    chk("R4 eoc low", {15'b0, eoc_n}, 16'h0);
    rd(1'b0, v); chk("R3 ready bit", v & 16'h0040, 16'h0040);
    chk("R2 status word", v, 16'h0040);
    rd(1'b1, v); chk("R8 word", v, 16'hBEEF);
    rd(1'b1, v); chk("R8 repeat", v, 16'hBEEF);
  endtask

  task automatic t_eoc_release();
    logic [15:0] v;
    wide_mode = 1'b1;
    convert(16'h1357);
    rd(1'b1, v);
    chk("R5 low after edge 1", {15'b0, eoc_n}, 16'h0);
    @(negedge clk); chk("R5 low after edge 2", {15'b0, eoc_n}, 16'h0);
    @(negedge clk); chk("R5 high after edge 3", {15'b0, eoc_n}, 16'h1);
    chk("R2 result", v, 16'h1357);
  endtask

  task automatic t_byte();
    logic [15:0] v;
    wide_mode = 1'b0;
    convert(16'hA55A);
    rd(1'b1, v); chk("R9 high byte", v, 16'h00A5);
    rd(1'b1, v); chk("R9 low byte", v, 16'h005A);
    rd(1'b1, v); chk("R9 wrap", v, 16'h00A5);
    convert(16'h1234);
    rd(1'b1, v); chk("R9 restart", v, 16'h0012);
    rd(1'b1, v); chk("R9 second", v, 16'h0034);
  endtask

  task automatic t_conv_start();
    logic [15:0] v;
    convert(16'h0F0F);
    chk("R4 eoc low", {15'b0, eoc_n}, 16'h0);
    @(negedge clk); hold_n = 1'b0;
    @(negedge clk); chk("R6 eoc high", {15'b0, eoc_n}, 16'h1);
    hold_n = 1'b1;
    rd(1'b0, v); chk("R3 ready cleared", v, 16'h0000);
  endtask

  task automatic t_ignored();
    logic [15:0] v;
    convert(16'h4242);
    rd(1'b0, v); chk("R11 status", v, 16'h0040);
    repeat (4) @(negedge clk);
    chk("R11 eoc kept", {15'b0, eoc_n}, 16'h0);
    rd(1'b0, v); chk("R11 status kept", v, 16'h0040);
  endtask

  task automatic t_sw_reset();
    logic [15:0] v;
    @(negedge clk); hold_n = 1'b0;
    @(negedge clk); done_pulse = 1'b1; done_result = 16'h7777;
    @(negedge clk); done_pulse = 1'b0;
    chk("R4 eoc low", {15'b0, eoc_n}, 16'h0);
    rd(1'b0, v);
    chk("R7 eoc high", {15'b0, eoc_n}, 16'h1);
    hold_n = 1'b1;
    rd(1'b0, v); chk("R7 cal request", v, 16'h0001);
    @(negedge clk); hold_n = 1'b0;
    @(negedge clk); hold_n = 1'b1;
    rd(1'b0, v); chk("R7 cal cleared", v, 16'h0000);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      failures++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    rst = 1'b1; cs_n = 1'b1; rd_n = 1'b1; addr_sel = 1'b0; hold_n = 1'b1;
    wide_mode = 1'b1; done_pulse = 1'b0; done_result = '0;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    t_reset();
    t_oe();
    t_wide();
    t_eoc_release();
    t_byte();
    t_conv_start();
    t_ignored();
    t_sw_reset();
    finished = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule